// File: doc/BRIEF.md
# Signed Word Condition Evaluator

This block decides whether a condition on 16-bit two's complement words holds and hands back a single true/false flag. A downstream enable uses that flag, the way a step in a control sequence only runs while its guarding condition is satisfied. One 4-bit opcode picks the test to run on the operands presented in that cycle.

Three families of test share the unit. Six relational tests compare operand A with operand B as signed numbers. A masked equality test compares A with B only on the bit positions that a mask word selects. A range test checks a test word against a low and a high limit. When the low limit is not above the high limit, the accepted band is inclusive. When the limits are swapped, the sense inverts, so that only values strictly inside the gap between them are rejected.

The evaluation itself is combinational. The outcome is captured in a register on each clock edge where the input strobe is high, and an output strobe marks the cycle in which a fresh outcome is present.

Top module: `swc_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` and `out_result` are both 0 after that edge.
- R2: Opcode 0 yields true exactly when A equals B. Opcode 1 yields true exactly when A differs from B.
- R3: Opcodes 2, 3, 4 and 5 yield A<B, A<=B, A>B and A>=B respectively, with both operands read as signed two's complement values from -32768 to +32767.
- R4: Opcode 6 yields true exactly when A and B agree on every bit where `mask_w` holds a 1. Bits where `mask_w` holds a 0 do not affect the outcome.
- R5: Opcode 7 with `lim_lo` <= `lim_hi` (signed) yields true exactly when `lim_lo` <= `lim_test` <= `lim_hi`, both ends included.
- R6: Opcode 7 with `lim_lo` > `lim_hi` (signed) yields false exactly when `lim_hi` < `lim_test` < `lim_lo`, and true otherwise, the two limit values included.
- R7: Opcodes 8 through 15 yield false.
- R8: At a clock edge with `in_valid` high, `out_result` takes the outcome for the inputs of that cycle. `out_valid` is the value `in_valid` had at the previous edge. At an edge with `in_valid` low, `out_result` keeps its value.
- R9: Inputs that the selected opcode does not read have no effect on the outcome. Relational tests ignore the mask and limit words, and the range test ignores A, B and the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Inputs of this cycle are to be evaluated |
| opcode | input | 4 | Test selector |
| opnd_a | input | 16 | Operand A, source word for the masked test |
| opnd_b | input | 16 | Operand B, compare word for the masked test |
| mask_w | input | 16 | Bit select for the masked equality test |
| lim_lo | input | 16 | Low limit of the range test |
| lim_test | input | 16 | Value checked by the range test |
| lim_hi | input | 16 | High limit of the range test |
| out_valid | output | 1 | A fresh outcome is on `out_result` |
| out_result | output | 1 | Registered condition outcome |

## Verification
Two effects of the range test can decide the same evaluation: inclusion of the limit endpoints, and the inversion that follows swapped limits. When the test word sits on a limit of a swapped pair, or when both limits are equal, the outcome depends on both effects at once. The bench provokes this by sweeping every combination of low, high and test drawn from a set of values that includes the limits, their neighbours and both signed extremes. It judges each outcome against a signed-integer formula computed separately for the ordered and the swapped case.

// File: rtl/swc_pkg.sv
// Package: shared opcode encoding and flag types for the signed word
// condition evaluator. Assumes a 4-bit opcode field; unlisted codes are
// treated as "always false" by the selector.
package swc_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_EQ    = 4'd0,
        OPC_NE    = 4'd1,
        OPC_LT    = 4'd2,
        OPC_LE    = 4'd3,
        OPC_GT    = 4'd4,
        OPC_GE    = 4'd5,
        OPC_MSKEQ = 4'd6,
        OPC_RANGE = 4'd7
    } swc_opc_e;

    typedef struct packed {
        logic eq;
        logic ne;
        logic lt;
        logic le;
        logic gt;
        logic ge;
    } swc_rel_t;

endpackage

// File: rtl/swc_relational.sv
// Module: swc_relational
// Produces all six signed relations between two words from a single
// equality and a single signed less-than. Assumes two's complement operands.
module swc_relational #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output swc_pkg::swc_rel_t rel_o
);

    logic is_eq;
    logic is_lt;

    // Two primitive comparisons feed every relation.
    always_comb begin
        is_eq = (a_in == b_in);
        is_lt = ($signed(a_in) < $signed(b_in));
    end

    // Derive the remaining relations from the primitives.
    always_comb begin
        rel_o.eq = is_eq;
        rel_o.ne = ~is_eq;
        rel_o.lt = is_lt;
        rel_o.le = is_lt | is_eq;
        rel_o.gt = ~(is_lt | is_eq);
        rel_o.ge = ~is_lt;
    end

endmodule

// File: rtl/swc_mask_match.sv
// Module: swc_mask_match
// Bitwise masked equality: a bit position takes part when its mask bit is 1.
// Assumes all three words share the same width.
module swc_mask_match #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] src_in,
    input  logic [WIDTH-1:0] ref_in,
    input  logic [WIDTH-1:0] sel_in,
    output logic             match_o
);

    logic [WIDTH-1:0] miss;

    // One mismatch detector per bit position.
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        always_comb miss[gi] = sel_in[gi] & (src_in[gi] ^ ref_in[gi]);
    end

    // Match when no selected bit disagrees.
    always_comb match_o = ~|miss;

endmodule

// File: rtl/swc_window.sv
// Module: swc_window
// Signed range test. Ordered limits give an inclusive band; swapped limits
// reject only values strictly between them. Assumes two's complement words.
module swc_window #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] lo_in,
    input  logic [WIDTH-1:0] val_in,
    input  logic [WIDTH-1:0] hi_in,
    output logic             inside_o
);

    logic ordered;
    logic above_lo;
    logic below_hi;

    // Three signed comparisons, shared by both senses.
    always_comb begin
        ordered  = ($signed(lo_in)  <= $signed(hi_in));
        above_lo = ($signed(val_in) >= $signed(lo_in));
        below_hi = ($signed(val_in) <= $signed(hi_in));
    end

    // Ordered limits need both bounds; swapped limits need either.
    always_comb inside_o = ordered ? (above_lo & below_hi) : (above_lo | below_hi);

endmodule

// File: rtl/swc_unit.sv
// Module: swc_unit (top)
// Selects one condition by opcode and registers the outcome with a strobe.
// Assumes synchronous active-low reset; unused opcodes evaluate false.
module swc_unit #(
    parameter int WIDTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [swc_pkg::OPC_W-1:0] opcode,
    input  logic [WIDTH-1:0]         opnd_a,
    input  logic [WIDTH-1:0]         opnd_b,
    input  logic [WIDTH-1:0]         mask_w,
    input  logic [WIDTH-1:0]         lim_lo,
    input  logic [WIDTH-1:0]         lim_test,
    input  logic [WIDTH-1:0]         lim_hi,
    output logic                     out_valid,
    output logic                     out_result
);

    import swc_pkg::*;

    swc_rel_t rel;
    logic     mask_hit;
    logic     win_hit;
    logic     cond_next;

    swc_relational #(.WIDTH(WIDTH)) u_rel (
        .a_in  (opnd_a),
        .b_in  (opnd_b),
        .rel_o (rel)
    );

    swc_mask_match #(.WIDTH(WIDTH)) u_mask (
        .src_in  (opnd_a),
        .ref_in  (opnd_b),
        .sel_in  (mask_w),
        .match_o (mask_hit)
    );

    swc_window #(.WIDTH(WIDTH)) u_win (
        .lo_in    (lim_lo),
        .val_in   (lim_test),
        .hi_in    (lim_hi),
        .inside_o (win_hit)
    );

    // Route the flag chosen by the opcode.
    always_comb begin
        case (opcode)
            OPC_EQ:    cond_next = rel.eq;
            OPC_NE:    cond_next = rel.ne;
            OPC_LT:    cond_next = rel.lt;
            OPC_LE:    cond_next = rel.le;
            OPC_GT:    cond_next = rel.gt;
            OPC_GE:    cond_next = rel.ge;
            OPC_MSKEQ: cond_next = mask_hit;
            OPC_RANGE: cond_next = win_hit;
            default:   cond_next = 1'b0;
        endcase
    end

    // Output strobe tracks the input strobe one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture the outcome only for strobed inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_result <= 1'b0;
        else if (in_valid) out_result <= cond_next;
    end

endmodule

// File: rtl/swc_unit_chk.sv
// Module: swc_unit_chk
// Temporal properties over the top-level ports, attached by bind.
module swc_unit_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [3:0]       opcode,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [WIDTH-1:0] lim_lo,
    input logic [WIDTH-1:0] lim_test,
    input logic [WIDTH-1:0] lim_hi,
    input logic             out_valid,
    input logic             out_result
);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_result));

    a_r8_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && !out_valid));

    a_r7_unused_false: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[3]) |=> !out_result);

    a_r2_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 4'd0 && opnd_a == opnd_b) |=> out_result);

    a_r6_gap_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 4'd7 &&
         $signed(lim_test) > $signed(lim_hi) &&
         $signed(lim_test) < $signed(lim_lo)) |=> !out_result);

    a_r5_band_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 4'd7 &&
         $signed(lim_test) >= $signed(lim_lo) &&
         $signed(lim_test) <= $signed(lim_hi)) |=> out_result);

endmodule

bind swc_unit swc_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .opcode     (opcode),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .lim_lo     (lim_lo),
    .lim_test   (lim_test),
    .lim_hi     (lim_hi),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/test_swc_unit.sv
// Bench: sweeps every opcode over a set of signed corner values and checks
// the registered outcome against arithmetic computed here.
module test_swc_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  opcode = '0;
    logic [15:0] opnd_a = '0, opnd_b = '0, mask_w = '0;
    logic [15:0] lim_lo = '0, lim_test = '0, lim_hi = '0;
    logic        out_valid, out_result;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] vals [NV];
    logic [15:0] lfsr = 16'hACE1;

    swc_unit i_swc_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .mask_w(mask_w),
        .lim_lo(lim_lo), .lim_test(lim_test), .lim_hi(lim_hi),
        .out_valid(out_valid), .out_result(out_result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (op %0d a %h b %h m %h lo %h t %h hi %h)",
                     req, act, exp, opcode, opnd_a, opnd_b, mask_w, lim_lo, lim_test, lim_hi);
        end
    endtask

    function automatic logic model(input logic [3:0] op, input logic [15:0] a,
                                   input logic [15:0] b, input logic [15:0] m,
                                   input logic [15:0] lo, input logic [15:0] t,
                                   input logic [15:0] hi);
        int sa = $signed(a), sb = $signed(b);
        int slo = $signed(lo), st = $signed(t), shi = $signed(hi);
        case (op)
            4'd0: return sa == sb;
            4'd1: return sa != sb;
            4'd2: return sa < sb;
            4'd3: return sa <= sb;
            4'd4: return sa > sb;
            4'd5: return sa >= sb;
            4'd6: return ((a & m) == (b & m));
            4'd7: return (slo <= shi) ? (st >= slo && st <= shi)
                                      : !(st > shi && st < slo);
            default: return 1'b0;
        endcase
    endfunction

    // Drive one strobed vector, then judge it one cycle later.
    task automatic run(input string req, input logic [3:0] op, input logic [15:0] a,
                       input logic [15:0] b, input logic [15:0] m, input logic [15:0] lo,
                       input logic [15:0] t, input logic [15:0] hi);
        @(negedge clk);
        in_valid = 1'b1; opcode = op; opnd_a = a; opnd_b = b; mask_w = m;
        lim_lo = lo; lim_test = t; lim_hi = hi;
        @(negedge clk);
        chk({req, " valid"}, out_valid, 1'b1);
        chk(req, out_result, model(op, a, b, m, lo, t, hi));
    endtask

    function automatic logic [15:0] nxt(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        vals = '{16'h8000, 16'h8001, 16'hFFFE, 16'hFFFF, 16'h0000, 16'h0001,
                 16'h0002, 16'h0005, 16'h0006, 16'h0007, 16'h0008, 16'h7FFE, 16'h7FFF};
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 valid", out_valid, 1'b0);
        chk("R1 result", out_result, 1'b0);
        rst_n = 1'b1;

        // R2, R3: all relational codes over signed corner pairs
        for (int op = 0; op < 6; op++)
            for (int i = 0; i < NV; i++)
                for (int j = 0; j < NV; j++)
                    run(op < 2 ? "R2" : "R3", 4'(op), vals[i], vals[j],
                        16'h0000, 16'h0000, 16'h0000, 16'h0000);

        // R4: masked equality, pseudo-random words plus full and empty masks
        for (int k = 0; k < 600; k++) begin
            logic [15:0] a, m, flip;
            lfsr = nxt(lfsr); a = lfsr;
            lfsr = nxt(lfsr); m = (k % 50 == 0) ? 16'h0000 : (k % 50 == 1) ? 16'hFFFF : lfsr;
            lfsr = nxt(lfsr); flip = (k % 3 == 0) ? 16'h0000 : (lfsr & (k % 2 == 0 ? ~m : 16'hFFFF));
            run("R4", 4'd6, a, a ^ flip, m, 16'h0000, 16'h0000, 16'h0000);
        end

        // R5, R6: range test, ordered and swapped limits including equal ones
        for (int i = 0; i < NV; i++)
            for (int j = 0; j < NV; j++)
                for (int k = 0; k < NV; k++)
                    run(($signed(vals[i]) <= $signed(vals[j])) ? "R5" : "R6", 4'd7,
                        16'h0000, 16'h0000, 16'h0000, vals[i], vals[k], vals[j]);

        // R7: unused codes stay false even when operands and limits would match
        for (int op = 8; op < 16; op++)
            for (int i = 0; i < 6; i++)
                run("R7", 4'(op), vals[i], vals[i], 16'hFFFF, vals[0], vals[i], vals[12]);

        // R9: unread inputs varied wildly must not change the outcome
        for (int k = 0; k < 200; k++) begin
            logic [15:0] x, y, z;
            lfsr = nxt(lfsr); x = lfsr; lfsr = nxt(lfsr); y = lfsr; lfsr = nxt(lfsr); z = lfsr;
            run("R9", 4'(k % 6), vals[k % NV], vals[(k * 7) % NV], x, y, z, x ^ y);
            run("R9", 4'd7, x, y, z, vals[k % NV], vals[(k * 5) % NV], vals[(k * 3) % NV]);
        end

        // R8: hold while idle, then a strobed vector captures again
        run("R8", 4'd0, 16'h1234, 16'h1234, 16'h0, 16'h0, 16'h0, 16'h0);
        @(negedge clk);
        in_valid = 1'b0; opcode = 4'd1;
        @(negedge clk);
        chk("R8 idle valid", out_valid, 1'b0);
        chk("R8 idle hold", out_result, 1'b1);
        opnd_b = 16'h0000;
        @(negedge clk);
        chk("R8 idle hold2", out_result, 1'b1);
        run("R8", 4'd1, 16'h1234, 16'h0000, 16'h0, 16'h0, 16'h0, 16'h0);
        run("R8", 4'd7, 16'h0, 16'h0, 16'h0, 16'h0008, 16'h0006, 16'h0005);

        // R1: reset mid-stream clears a true outcome
        run("R1", 4'd0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid valid", out_valid, 1'b0);
        chk("R1 mid result", out_result, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule